// File: doc/BRIEF.md
# Windowed Rising-Transition Counter

This block watches a single response line whose sampled level is one of three states (low, high or undefined) and measures it over a window bounded by two control edges. Software first issues an arm pulse, which clears every result. The window then opens on the next edge of the chosen polarity on the start line and closes on an edge of the chosen polarity on the stop line. While the window is open, every sample whose clock is selected and whose enable qualifier passes can advance a rising-transition counter and set sticky level-history flags.

The sample clock is chosen among three strobes: an external clock tick, an internal pod sync strobe, or a capture pulse from a vector sequencer. The enable qualifier follows an external enable line (active high or active low) or is always true. It can additionally be gated by the internal sync line. All strobes are single-cycle, synchronous to `clk`.

Top module: `edge_window_counter`

## Requirements
- R1: After reset, and in the cycle after an `arm` pulse in any state, `count` is 0, `seen_lo`, `seen_hi`, `seen_x`, `done` and `win_open` are 0.
- R2: The window opens (`win_open` high) in the cycle after a start edge seen while armed. Start edges with no prior arm are ignored. Samples taken before the window opens change neither the count nor the flags.
- R3: Level code 2'b00 is low, 2'b01 is high, 2'b10 and 2'b11 are undefined. A sample in the window counts one transition when it is high and the previous in-window sample was low or undefined. The first sample of a window never counts.
- R4: A stop edge while the window is open closes it in the next cycle and raises `done`. A sample in the same cycle as that stop edge is discarded. `done` stays high, and count and flags stay frozen, until the next arm.
- R5: `en_mode` 2'b01 qualifies samples while `en_in` is 1, 2'b10 while `en_in` is 0, 2'b00 and 2'b11 always. When `en_use_sync` is 1 the qualifier also requires `pod_sync` to be 1. Unqualified samples neither count nor set flags, but still become the previous level for the next sample.
- R6: `clk_sel` 2'b00 samples on `ext_tick`, 2'b01 on `pod_sync`, 2'b10 on `cap_pulse`, and 2'b11 takes no samples. Strobes that are not selected are ignored.
- R7: `seen_lo`, `seen_hi` and `seen_x` each become 1 on a qualified in-window sample of that level and stay 1 until the next arm.
- R8: The counter is CNT_W bits wide and holds at its all-ones value instead of wrapping.
- R9: `start_pol` and `stop_pol` pick the edge that is recognised: 0 for a rising edge, 1 for a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Clears the results and waits for a start edge |
| start_pol | input | 1 | Start edge polarity (0 rising, 1 falling) |
| stop_pol | input | 1 | Stop edge polarity (0 rising, 1 falling) |
| start_in | input | 1 | Start line |
| stop_in | input | 1 | Stop line |
| clk_sel | input | 2 | Sample clock source select |
| ext_tick | input | 1 | External sample clock strobe |
| pod_sync | input | 1 | Internal sync strobe, also an enable companion |
| cap_pulse | input | 1 | Capture pulse from the vector sequencer |
| en_mode | input | 2 | Enable qualifier mode |
| en_use_sync | input | 1 | Also require pod_sync for qualification |
| en_in | input | 1 | External enable line |
| lvl_in | input | 2 | Three-state level code of the observed line |
| count | output | CNT_W | Rising transitions counted |
| seen_lo | output | 1 | A qualified low sample was taken |
| seen_hi | output | 1 | A qualified high sample was taken |
| seen_x | output | 1 | A qualified undefined sample was taken |
| win_open | output | 1 | Measurement window is open |
| done | output | 1 | Window has closed since the last arm |

## Verification
A wrong window state shows at the ports in the cycle after the edge or arm that should have moved it: `win_open` or `done` takes the wrong value, and the count and flags go on changing when they should be frozen. A corrupted previous-level register shows only on the next in-window sample, as a count one higher or lower than expected. That is why the sweep pairs every two-sample level combination with every qualifier setting. Saturation and stop-priority faults show as a count off by one at the very next sample.

// File: rtl/ewc_pkg.sv
// Package: shared state encoding and level-code helpers for the
// windowed rising-transition counter.
// Assumes level codes: 2'b00 low, 2'b01 high, 2'b1x undefined.
package ewc_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_OPEN  = 2'd2,
        WS_DONE  = 2'd3
    } win_state_t;

    localparam logic [1:0] LV_LOW  = 2'b00;
    localparam logic [1:0] LV_HIGH = 2'b01;

    localparam logic [1:0] CS_EXT  = 2'b00;
    localparam logic [1:0] CS_POD  = 2'b01;
    localparam logic [1:0] CS_CAP  = 2'b10;

    localparam logic [1:0] EM_HIGH = 2'b01;
    localparam logic [1:0] EM_LOW  = 2'b10;

    function automatic logic lv_is_high(input logic [1:0] lv);
        return lv == LV_HIGH;
    endfunction

    function automatic logic lv_is_low(input logic [1:0] lv);
        return lv == LV_LOW;
    endfunction

    function automatic logic lv_is_x(input logic [1:0] lv);
        return lv[1];
    endfunction

endpackage

// File: rtl/ewc_edge_sense.sv
// Module: detects one edge of a selectable polarity on a synchronous line.
// Assumes the line is already synchronous to clk; hit is combinational
// from the current level and the registered previous level.
module ewc_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic falling,
    output logic hit
);
    logic sig_q;

    // Hold the previous level of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // Edge of the requested polarity in this cycle.
    always_comb begin
        hit = falling ? (sig_q & ~sig) : (~sig_q & sig);
    end

    // R9
    edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sig == ~falling));
endmodule

// File: rtl/ewc_sample_gate.sv
// Module: chooses the sample strobe and evaluates the enable qualifier.
// Assumes all strobes are single-cycle and synchronous to the block clock.
module ewc_sample_gate
    import ewc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       ext_tick,
    input  logic       pod_sync,
    input  logic       cap_pulse,
    input  logic [1:0] en_mode,
    input  logic       en_use_sync,
    input  logic       en_in,
    output logic       tick,
    output logic       qual
);
    logic mode_ok;

    // Select the sample strobe.
    always_comb begin
        unique case (clk_sel)
            CS_EXT:  tick = ext_tick;
            CS_POD:  tick = pod_sync;
            CS_CAP:  tick = cap_pulse;
            default: tick = 1'b0;
        endcase
    end

    // Level condition of the enable, then the optional sync gating.
    always_comb begin
        unique case (en_mode)
            EM_HIGH: mode_ok = en_in;
            EM_LOW:  mode_ok = ~en_in;
            default: mode_ok = 1'b1;
        endcase
        qual = mode_ok & (pod_sync | ~en_use_sync);
    end

    // R6
    no_tick_sel3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b11) |-> !tick);
    // R5
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_use_sync && !pod_sync) |-> !qual);
endmodule

// File: rtl/ewc_level_tracker.sv
// Module: keeps the previous in-window level, the saturating rising
// transition counter and the sticky level-history flags.
// Assumes take is raised only for in-window samples that are not
// pre-empted by a stop edge, and clear has priority over take.
module ewc_level_tracker
    import ewc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             qual,
    input  logic [1:0]       lvl,
    output logic [CNT_W-1:0] count,
    output logic             seen_lo,
    output logic             seen_hi,
    output logic             seen_x
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [1:0] prev_lv;
    logic       prev_ok;
    logic       rise;

    // A rise is high now after a low or undefined previous sample.
    always_comb begin
        rise = prev_ok & lv_is_high(lvl) & ~lv_is_high(prev_lv);
    end

    // Previous level register, valid only after the first sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prev_lv <= LV_LOW;
            prev_ok <= 1'b0;
        end else if (take) begin
            prev_lv <= lvl;
            prev_ok <= 1'b1;
        end
    end

    // Saturating counter of qualified rising transitions.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                           count <= '0;
        else if (take && qual && rise && count != CNT_MAX) count <= count + 1'b1;
    end

    // Sticky history flags for qualified samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen_lo <= 1'b0;
            seen_hi <= 1'b0;
            seen_x  <= 1'b0;
        end else if (take && qual) begin
            seen_lo <= seen_lo | lv_is_low(lvl);
            seen_hi <= seen_hi | lv_is_high(lvl);
            seen_x  <= seen_x  | lv_is_x(lvl);
        end
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count == $past(count) || count == $past(count) + 1'b1));
    // R8
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && count == CNT_MAX) |=> count == CNT_MAX);
    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && (seen_lo || seen_hi || seen_x))
        |=> ($countones({seen_lo, seen_hi, seen_x}) >=
             $countones($past({seen_lo, seen_hi, seen_x}))));
    // R3
    first_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !prev_ok) |=> $stable(count));
endmodule

// File: rtl/edge_window_counter.sv
// Module: top of the windowed rising-transition counter. Holds the
// arm/start/stop window state and drives the level tracker.
// Assumes every input is synchronous to clk; arm wins over every edge.
module edge_window_counter
    import ewc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             start_pol,
    input  logic             stop_pol,
    input  logic             start_in,
    input  logic             stop_in,
    input  logic [1:0]       clk_sel,
    input  logic             ext_tick,
    input  logic             pod_sync,
    input  logic             cap_pulse,
    input  logic [1:0]       en_mode,
    input  logic             en_use_sync,
    input  logic             en_in,
    input  logic [1:0]       lvl_in,
    output logic [CNT_W-1:0] count,
    output logic             seen_lo,
    output logic             seen_hi,
    output logic             seen_x,
    output logic             win_open,
    output logic             done
);
    win_state_t state;
    logic start_hit;
    logic stop_hit;
    logic tick;
    logic qual;
    logic take;

    ewc_edge_sense u_start (
        .clk(clk), .rst_n(rst_n), .sig(start_in), .falling(start_pol), .hit(start_hit)
    );

    ewc_edge_sense u_stop (
        .clk(clk), .rst_n(rst_n), .sig(stop_in), .falling(stop_pol), .hit(stop_hit)
    );

    ewc_sample_gate u_gate (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_tick(ext_tick),
        .pod_sync(pod_sync), .cap_pulse(cap_pulse), .en_mode(en_mode),
        .en_use_sync(en_use_sync), .en_in(en_in), .tick(tick), .qual(qual)
    );

    // Window state: arm first, then start opens, stop closes.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else if (arm) state <= WS_ARMED;
        else begin
            unique case (state)
                WS_ARMED: if (start_hit) state <= WS_OPEN;
                WS_OPEN:  if (stop_hit)  state <= WS_DONE;
                default:  state <= state;
            endcase
        end
    end

    // A sample is taken in the open window unless a stop edge pre-empts it.
    always_comb begin
        take = (state == WS_OPEN) & tick & ~stop_hit & ~arm;
    end

    ewc_level_tracker #(.CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(arm), .take(take), .qual(qual),
        .lvl(lvl_in), .count(count), .seen_lo(seen_lo), .seen_hi(seen_hi),
        .seen_x(seen_x)
    );

    // Status outputs decoded from the window state.
    always_comb begin
        win_open = (state == WS_OPEN);
        done     = (state == WS_DONE);
    end

    // R1
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == '0 && !seen_lo && !seen_hi && !seen_x && !done && !win_open));
    // R2
    closed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !arm) |=> ($stable(count) && $stable({seen_lo, seen_hi, seen_x})));
    // R2
    open_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(state == WS_ARMED));
    // R4
    stop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && stop_hit && !arm) |=> (done && $stable(count)));
    // R4
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);
    // R4
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_open, done}));
endmodule

// File: tb/edge_window_counter_bench.sv
module edge_window_counter_bench;
    localparam int W = 6;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, start_pol = 0, stop_pol = 0, start_in = 0, stop_in = 0;
    logic [1:0] clk_sel = 2'b00;
    logic ext_tick = 0, pod_sync = 0, cap_pulse = 0;
    logic [1:0] en_mode = 2'b00;
    logic en_use_sync = 0, en_in = 0;
    logic [1:0] lvl_in = 2'b00;
    logic [W-1:0] count;
    logic seen_lo, seen_hi, seen_x, win_open, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    edge_window_counter #(.CNT_W(W)) u_edge_window_counter (
        .clk(clk), .rst_n(rst_n), .arm(arm), .start_pol(start_pol), .stop_pol(stop_pol),
        .start_in(start_in), .stop_in(stop_in), .clk_sel(clk_sel), .ext_tick(ext_tick),
        .pod_sync(pod_sync), .cap_pulse(cap_pulse), .en_mode(en_mode),
        .en_use_sync(en_use_sync), .en_in(en_in), .lvl_in(lvl_in), .count(count),
        .seen_lo(seen_lo), .seen_hi(seen_hi), .seen_x(seen_x), .win_open(win_open),
        .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Arm with start/stop lines at their idle levels.
    task automatic do_arm();
        arm = 1; start_in = start_pol; stop_in = stop_pol;
        cyc();
        arm = 0;
    endtask

    task automatic do_start();
        start_in = ~start_pol;
        cyc();
    endtask

    task automatic do_stop();
        stop_in = ~stop_pol;
        cyc();
    endtask

    task automatic sample(input logic [1:0] lv, input logic e, input logic p, input logic c);
        lvl_in = lv; ext_tick = e; pod_sync = p; cap_pulse = c;
        cyc();
        ext_tick = 0; pod_sync = 0; cap_pulse = 0;
    endtask

    function automatic int flags3();
        return {29'd0, seen_lo, seen_hi, seen_x};
    endfunction

    function automatic int flag_of(input logic [1:0] lv);
        if (lv == 2'b00) return 4;
        if (lv == 2'b01) return 2;
        return 1;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        cyc();
        // R1 reset state
        check("R1 reset count", count, 0);
        check("R1 reset flags", flags3(), 0);
        check("R1 reset done/open", {done, win_open}, 0);

        // R2 start edge without arm ignored
        do_start();
        check("R2 start without arm", win_open, 0);
        start_in = 0; cyc();

        // R2 samples before start ignored; R3 first sample never counts
        do_arm();
        sample(2'b00, 1, 0, 0);
        sample(2'b01, 1, 0, 0);
        check("R2 pre-window count", count, 0);
        check("R2 pre-window flags", flags3(), 0);
        do_start();
        check("R2 window open", win_open, 1);
        sample(2'b01, 1, 0, 0);
        check("R3 first sample high no count", count, 0);
        sample(2'b01, 1, 0, 0);
        check("R3 high to high no count", count, 0);
        sample(2'b10, 1, 0, 0);
        sample(2'b01, 1, 0, 0);
        check("R3 undefined to high counts", count, 1);
        sample(2'b00, 1, 0, 0);
        check("R3 high to low no count", count, 1);

        // R3 R5 R7 sweep of level pairs against every qualifier setting
        for (int em = 0; em < 4; em++)
          for (int us = 0; us < 2; us++)
            for (int ei = 0; ei < 2; ei++)
              for (int ps = 0; ps < 2; ps++)
                for (int a = 0; a < 4; a++)
                  for (int b = 0; b < 4; b++) begin
                      bit q;
                      int expc, expf;
                      en_mode = em[1:0]; en_use_sync = us[0]; en_in = ei[0];
                      clk_sel = 2'b00;
                      do_arm();
                      do_start();
                      sample(a[1:0], 1, ps[0], 0);
                      sample(b[1:0], 1, ps[0], 0);
                      q = (em == 1) ? (ei == 1) : (em == 2) ? (ei == 0) : 1'b1;
                      q = q && (us == 0 || ps == 1);
                      expc = (q && b == 1 && a != 1) ? 1 : 0;
                      expf = q ? (flag_of(a[1:0]) | flag_of(b[1:0])) : 0;
                      check("R3/R5 sweep count", count, expc);
                      check("R7/R5 sweep flags", flags3(), expf);
                      do_stop();
                      check("R4 sweep done", done, 1);
                  end
        en_mode = 0; en_use_sync = 0;

        // R5 unqualified low still becomes the previous level
        en_mode = 2'b01;
        do_arm(); do_start();
        en_in = 0; sample(2'b00, 1, 0, 0);
        en_in = 1; sample(2'b01, 1, 0, 0);
        check("R5 disabled low then enabled high", count, 1);
        check("R5 disabled low sets no flag", flags3(), 2);
        en_mode = 2'b00;

        // R4 stop in same cycle as a rising sample: sample dropped
        do_arm(); do_start();
        sample(2'b00, 1, 0, 0);
        lvl_in = 2'b01; ext_tick = 1; stop_in = ~stop_pol;
        cyc();
        ext_tick = 0;
        check("R4 stop pre-empts sample count", count, 0);
        check("R4 stop pre-empts sample flags", flags3(), 4);
        check("R4 done raised", done, 1);
        sample(2'b00, 1, 0, 0);
        sample(2'b01, 1, 0, 0);
        repeat (5) cyc();
        check("R4 frozen after close", count, 0);
        check("R4 done holds", done, 1);
        do_arm();
        check("R1 arm clears done", done, 0);

        // R9 falling polarity for start and stop
        start_pol = 1; stop_pol = 1;
        do_arm();
        start_in = 1; cyc();
        check("R9 rising start ignored for falling", win_open, 1'b0);
        start_in = 0; cyc();
        check("R9 falling start opens", win_open, 1);
        stop_in = 0; cyc();
        check("R9 falling stop closes", done, 1);
        start_pol = 0; stop_pol = 0;

        // R6 source selection
        clk_sel = 2'b01;
        do_arm(); do_start();
        sample(2'b00, 0, 1, 0);
        sample(2'b01, 1, 0, 1);
        sample(2'b01, 0, 1, 0);
        check("R6 pod sync source", count, 1);
        clk_sel = 2'b10;
        do_arm(); do_start();
        sample(2'b00, 0, 0, 1);
        sample(2'b01, 1, 1, 0);
        check("R6 capture ignores other strobes", count, 0);
        sample(2'b01, 0, 0, 1);
        check("R6 capture source", count, 1);
        clk_sel = 2'b11;
        do_arm(); do_start();
        sample(2'b00, 1, 1, 1);
        sample(2'b01, 1, 1, 1);
        check("R6 no source count", count, 0);
        check("R6 no source flags", flags3(), 0);
        clk_sel = 2'b00;

        // R8 saturation
        do_arm(); do_start();
        for (int i = 0; i < MAXC + 5; i++) begin
            sample(2'b00, 1, 0, 0);
            sample(2'b01, 1, 0, 0);
        end
        check("R8 saturates", count, MAXC);

        // R1 arm in an open window clears and re-arms
        do_arm();
        check("R1 arm mid-window count", count, 0);
        check("R1 arm mid-window open", win_open, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule